// File: doc/BRIEF.md
# Skip-Test Memory Execution Unit

This unit executes the conditional-skip and nibble-swap operations of an 8-bit accumulator microcontroller on one data-memory operand. The sequencer hands it a decoded operation code, the operand fetched from data memory and a 3-bit bit index. The unit returns a write-back value and a write-back target (data memory or the accumulator). It also returns a skip request, which tells the program-counter logic to discard the next instruction.

One instruction cycle is four system clocks. Every operation takes one instruction cycle. When the skip is taken, the unit stays busy for one more instruction cycle, so the whole operation takes eight clocks. No operation touches a status flag, so the unit has no flag output.

The input side is a valid/ready handshake. `in_ready` is high only while the unit is idle. An `in_valid` presented while `in_ready` is low is ignored and is never queued. The outputs are plain pulses with no back-pressure: the consumer must take `wb_valid`, `skip` and `done` in the clock in which they appear.

Top module: `skip_exec_unit`

## Requirements
- R1: After reset `in_ready` is 1, and `wb_valid`, `skip` and `done` are 0.
- R2: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the operation finishes. Any `in_valid` seen while `in_ready` is 0 has no effect: the results are unchanged and no further operation runs.
- R3: Code 0 (zero test) and code 1 (zero test with move) request a skip exactly when the operand is 0. Code 0 writes nothing. Code 1 writes the operand to the accumulator (`wb_to_acc`=1).
- R4: Code 2 requests a skip when bit `in_bit` of the operand is 0. Code 3 requests a skip when that bit is 1. Neither code writes anything.
- R5: Code 4 writes operand+1 to memory (`wb_to_acc`=0) and code 5 writes operand-1 to memory. Both wrap modulo 256 and request a skip when the new value is 0.
- R6: Codes 6 and 7 compute the same values as codes 4 and 5. They write the result to the accumulator (`wb_to_acc`=1), leave memory unwritten and skip on a zero result.
- R7: Code 8 writes the operand with its two nibbles exchanged to memory. Code 9 writes the same value to the accumulator. Neither code ever skips.
- R8: Counting the accept edge as clock 0, `wb_valid` and `skip` appear in clock 4. `done` appears in clock 4 when no skip is taken and in clock 8 when one is. `in_ready` returns to 1 in the clock after `done`.
- R9: `wb_valid`, `skip` and `done` are each at most a single-clock pulse per operation. `wb_valid` is raised only by codes that write.
- R10: Codes 10 to 15 write nothing, never skip and finish in clock 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation will be taken |
| in_op | input | 4 | Operation code |
| in_data | input | 8 | Data-memory operand |
| in_bit | input | 3 | Bit index for bit tests |
| wb_valid | output | 1 | Write-back strobe |
| wb_to_acc | output | 1 | Write-back target: 1 accumulator, 0 memory |
| wb_data | output | 8 | Write-back value |
| skip | output | 1 | Skip-next-instruction pulse |
| done | output | 1 | Last clock of the operation |

## Verification
A wrong phase or cycle count moves the pulses away from clocks 4 and 8. The bench sees this in the first operation that runs, because it records the exact clock of every pulse. A wrongly latched operand or operation code shows up as a bad value or target at the next write-back. A wrong skip decision shows up twice in that same operation: once in `skip` and again as a `done` that arrives four clocks early or late. A busy flag that drops too soon lets an ignored strobe start a second operation, and the bench sees the extra write-back within four clocks.

// File: rtl/skx_pkg.sv
package skx_pkg;
  typedef enum logic [3:0] {
    OP_TSTZ    = 4'd0,
    OP_TSTZ_MV = 4'd1,
    OP_BIT_CLR = 4'd2,
    OP_BIT_SET = 4'd3,
    OP_INC_M   = 4'd4,
    OP_DEC_M   = 4'd5,
    OP_INC_A   = 4'd6,
    OP_DEC_A   = 4'd7,
    OP_SWP_M   = 4'd8,
    OP_SWP_A   = 4'd9
  } skx_op_e;
endpackage

// File: rtl/skx_alu.sv
module skx_alu import skx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [BIT_W-1:0]  bit_sel,
  output logic [DATA_W-1:0] result,
  output logic              writes,
  output logic              to_acc,
  output logic              take_skip
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] plus1, minus1, swapped;
  logic              sel_bit;

  assign plus1   = operand + 1'b1;
  assign minus1  = operand - 1'b1;
  assign swapped = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
  assign sel_bit = operand[bit_sel];

  always_comb begin
    result    = '0;
    writes    = 1'b0;
    to_acc    = 1'b0;
    take_skip = 1'b0;
    case (skx_op_e'(op))
      OP_TSTZ:    take_skip = (operand == '0);
      OP_TSTZ_MV: begin
        result = operand; writes = 1'b1; to_acc = 1'b1;
        take_skip = (operand == '0);
      end
      OP_BIT_CLR: take_skip = !sel_bit;
      OP_BIT_SET: take_skip = sel_bit;
      OP_INC_M, OP_INC_A: begin
        result = plus1; writes = 1'b1; to_acc = (op == OP_INC_A);
        take_skip = (plus1 == '0);
      end
      OP_DEC_M, OP_DEC_A: begin
        result = minus1; writes = 1'b1; to_acc = (op == OP_DEC_A);
        take_skip = (minus1 == '0);
      end
      OP_SWP_M, OP_SWP_A: begin
        result = swapped; writes = 1'b1; to_acc = (op == OP_SWP_A);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/skx_timer.sv
module skx_timer #(
  parameter int CLKS_PER_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stretch,
  output logic busy,
  output logic slot,
  output logic fin
);
  localparam int PH_W = (CLKS_PER_CYC > 2) ? $clog2(CLKS_PER_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_CYC - 1);

  logic [PH_W-1:0] phase;
  logic            cyc;
  logic            cyc_last, ph_end;

  assign ph_end   = (phase == PH_LAST);
  assign cyc_last = (cyc == stretch);
  assign slot     = busy && ph_end && !cyc;
  assign fin      = busy && ph_end && cyc_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
      cyc   <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= '0;
      cyc   <= 1'b0;
    end else if (busy) begin
      if (ph_end) begin
        phase <= '0;
        if (cyc_last) busy <= 1'b0;
        else          cyc  <= 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/skip_exec_unit.sv
module skip_exec_unit #(
  parameter int DATA_W       = 8,
  parameter int BIT_W        = $clog2(DATA_W),
  parameter int CLKS_PER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BIT_W-1:0]  in_bit,
  output logic              wb_valid,
  output logic              wb_to_acc,
  output logic [DATA_W-1:0] wb_data,
  output logic              skip,
  output logic              done
);
  logic [3:0]        op_q;
  logic [DATA_W-1:0] data_q;
  logic [BIT_W-1:0]  bit_q;
  logic              accept, busy, slot, fin;
  logic              alu_writes, alu_acc, alu_skip;
  logic [DATA_W-1:0] alu_res;

  assign accept   = in_valid && !busy;
  assign in_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= 4'hF;
      data_q <= '0;
      bit_q  <= '0;
    end else if (accept) begin
      op_q   <= in_op;
      data_q <= in_data;
      bit_q  <= in_bit;
    end
  end

  skx_alu #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_alu (
    .op(op_q), .operand(data_q), .bit_sel(bit_q),
    .result(alu_res), .writes(alu_writes), .to_acc(alu_acc), .take_skip(alu_skip)
  );

  skx_timer #(.CLKS_PER_CYC(CLKS_PER_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .stretch(alu_skip),
    .busy(busy), .slot(slot), .fin(fin)
  );

  assign wb_valid  = slot && alu_writes;
  assign wb_to_acc = alu_acc;
  assign wb_data   = alu_res;
  assign skip      = slot && alu_skip;
  assign done      = fin;
endmodule

// File: rtl/skx_checker.sv
module skx_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic wb_valid,
  input logic skip,
  input logic done
);
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready) else $error("done while ready"); // R2
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready) else $error("accept not busy"); // R2
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready) else $error("ready not back"); // R8
  AST_SKIP_DEFERS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !done) else $error("skip finished early"); // R8
  AST_WB_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid) else $error("wb pulse long"); // R9
  AST_SKIP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> !skip) else $error("skip pulse long"); // R9
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done pulse long"); // R9
endmodule

bind skip_exec_unit skx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wb_valid(wb_valid), .skip(skip), .done(done)
);

// File: tb/skip_exec_unit_bench.sv
module skip_exec_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_data = '0;
  logic [2:0] in_bit = '0;
  logic       wb_valid, wb_to_acc, skip, done;
  logic [7:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  skip_exec_unit u_skip_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_bit(in_bit),
    .wb_valid(wb_valid), .wb_to_acc(wb_to_acc), .wb_data(wb_data),
    .skip(skip), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [7:0] d, input logic [2:0] b,
                       output bit w, output bit acc, output logic [7:0] v, output bit s);
    w = 0; acc = 0; v = 8'h00; s = 0;
    case (op)
      4'd0: s = (d == 8'h00);
      4'd1: begin w = 1; acc = 1; v = d; s = (d == 8'h00); end
      4'd2: s = !d[b];
      4'd3: s = d[b];
      4'd4, 4'd6: begin w = 1; acc = (op == 4'd6); v = d + 8'd1; s = (v == 8'h00); end
      4'd5, 4'd7: begin w = 1; acc = (op == 4'd7); v = d - 8'd1; s = (v == 8'h00); end
      4'd8, 4'd9: begin w = 1; acc = (op == 4'd9); v = {d[3:0], d[7:4]}; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] d, input logic [2:0] b,
                        input bit inject);
    bit ew, eacc, es;
    logic [7:0] ev;
    int wb_k, sk_k, dn_k, wb_n;
    string rq;
    model(op, d, b, ew, eacc, ev, es);
    rq = req_of(op);
    wb_k = 0; sk_k = 0; dn_k = 0; wb_n = 0;
    @(negedge clk);
    check(in_ready === 1'b1, "R2 ready before offer", in_ready, 1);
    in_valid = 1; in_op = op; in_data = d; in_bit = b;
    @(negedge clk);
    in_valid = 0;
    check(in_ready === 1'b0, "R2 busy after accept", in_ready, 0);
    for (int k = 1; k <= 12; k++) begin
      if (k > 1) @(negedge clk);
      if (inject && k == 2) begin
        in_valid = 1; in_op = 4'd4; in_data = ~d; in_bit = ~b;
      end
      if (wb_valid) begin
        wb_n++;
        if (wb_k == 0) wb_k = k;
        check(wb_data === ev, {rq, " wb value"}, wb_data, ev);
        check(wb_to_acc === eacc, {rq, " wb target"}, wb_to_acc, eacc);
      end
      if (skip && sk_k == 0) sk_k = k;
      if (done) begin
        dn_k = k;
        in_valid = 0;
        break;
      end
    end
    check(wb_n == (ew ? 1 : 0), {rq, " R9 write count"}, wb_n, ew ? 1 : 0);
    if (ew) check(wb_k == 4, "R8 wb clock", wb_k, 4);
    check(sk_k == (es ? 4 : 0), {rq, " skip decision/clock"}, sk_k, es ? 4 : 0);
    check(dn_k == (es ? 8 : 4), "R8 done clock", dn_k, es ? 8 : 4);
    @(negedge clk);
    check(in_ready === 1'b1, "R8 ready after done", in_ready, 1);
    if (inject) begin
      for (int k = 0; k < 6; k++) begin
        check(!wb_valid && !skip && !done, "R2 ignored strobe started work",
              {wb_valid, skip, done}, 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check(in_ready === 1'b1, "R1 ready in reset", in_ready, 1);
    check({wb_valid, skip, done} === 3'b000, "R1 pulses in reset", {wb_valid, skip, done}, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && {wb_valid, skip, done} === 3'b000, "R1 idle after reset",
          {in_ready, wb_valid, skip, done}, 4'b1000);
    // directed corners
    run_op(4'd0, 8'h00, 3'd0, 0);  // R3 zero skips
    run_op(4'd0, 8'h10, 3'd0, 0);  // R3 nonzero
    run_op(4'd1, 8'h00, 3'd0, 0);  // R3 move zero
    run_op(4'd1, 8'hA5, 3'd0, 0);
    run_op(4'd2, 8'hFE, 3'd0, 0);  // R4 bit0 clear
    run_op(4'd3, 8'h80, 3'd7, 0);  // R4 bit7 set
    run_op(4'd3, 8'h7F, 3'd7, 0);
    run_op(4'd4, 8'hFF, 3'd0, 0);  // R5 wrap to zero
    run_op(4'd5, 8'h01, 3'd0, 0);  // R5 to zero
    run_op(4'd5, 8'h00, 3'd0, 0);  // R5 wrap to FF
    run_op(4'd6, 8'hFF, 3'd0, 0);  // R6
    run_op(4'd7, 8'h42, 3'd0, 0);  // R6
    run_op(4'd8, 8'h3C, 3'd0, 0);  // R7
    run_op(4'd9, 8'h00, 3'd0, 0);  // R7 zero never skips
    run_op(4'd12, 8'h00, 3'd0, 0); // R10
    run_op(4'd5, 8'h01, 3'd2, 1);  // R2 strobe during skip op
    run_op(4'd8, 8'h12, 3'd2, 1);  // R2 strobe during short op
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d;
      int sel;
      sel = $urandom % 4;
      d = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : (sel == 2) ? 8'h01 : 8'($urandom);
      run_op(4'($urandom), d, 3'($urandom), ($urandom % 8) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule